// File: doc/BRIEF.md
# Overcurrent Breaker and Fault Timer

This block is the digital half of a hot-swap circuit breaker. Two comparator results arrive as clean synchronous flags. One says the sense-resistor drop is above the base overcurrent threshold. The other says it is above the fast-trip threshold. The block decides when the external pass transistor must be switched off, and it raises an active-low fault indication. It then decides when the transistor may be switched on again. The analog comparators, the gate driver and the current-limiting loop sit outside the block.

A base overcurrent must persist through a programmable filter window before it trips the breaker. A fast-trip event trips the breaker on the next clock edge. When regulation mode is selected, the block asks the analog loop to limit current and starts a longer timeout in place of the filter window. That timeout restarts whenever the overcurrent goes away. After a trip the fault clears in one of two ways. In cycle mode it clears by itself after a cool-down period. In latched mode it clears only after a qualified low pulse on the clear pin, and the gate stays off for a further restart delay after that pulse. An optional sticky flag models a permanent fuse. Once it is set by a trip, it holds the fault until a dedicated configuration-clear input is raised, and neither the clear pin nor the block reset affects it.

All timing is counted in clock cycles: FILT_CYC for the filter window, REG_CYC for the regulation timeout, CYC_CYC for the cool-down, PDD_CYC for the restart delay and RST_MIN for the minimum clear pulse.

Top module: `cb_fault_timer`

## Requirements
- R1: While `rst_n` is sampled low, the breaker returns to the running state. After reset, `gate_off`=0, `fault_n`=1 and `reg_req`=0 as long as no sense flag is set and the sticky flag is clear.
- R2: With `reg_en`=0, a trip occurs on the edge where `oc_flag` has been sampled high on FILT_CYC+1 consecutive edges. A shorter run trips nothing, and a single low sample restarts the count.
- R3: With `qt_en`=1, `qt_flag` sampled high while running trips on that same edge, whatever the filter or regulation count holds. With `qt_en`=0, `qt_flag` has no effect.
- R4: With `reg_en`=1, `reg_req` is high exactly while the breaker runs and `oc_flag` is high. The trip then needs REG_CYC+1 consecutive high samples, and the FILT_CYC window does not apply.
- R5: In regulation mode, a low sample of `oc_flag` before the timeout restarts the timeout from zero.
- R6: On the edge that trips, `gate_off` goes to 1 and `fault_n` goes to 0.
- R7: With `cycle_mode`=1, `fault_n` stays low for exactly CYC_CYC cycles after the trip. Then `fault_n` returns to 1 and `gate_off` returns to 0 on the same edge.
- R8: With `cycle_mode`=0, the fault holds indefinitely. It clears on the first edge that samples `clr_n` high after at least RST_MIN consecutive low samples. `fault_n` rises on that edge, and `gate_off` stays 1 for PDD_CYC further cycles.
- R9: A low pulse on `clr_n` of fewer than RST_MIN sampled cycles is ignored, and the fault stays set.
- R10: A trip while `nv_en`=1 sets a sticky flag. While that flag is set, `fault_n`=0 and `gate_off`=1, whatever `clr_n`, `cycle_mode` or `rst_n` do.
- R11: `cfg_clear` sampled high clears the sticky flag on that edge. The outputs then follow the breaker state again.
- R12: If the overcurrent is still present after a restart, the breaker trips again under the same filter rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (does not touch the sticky flag) |
| oc_flag | input | 1 | Base overcurrent comparator result |
| qt_flag | input | 1 | Fast-trip comparator result |
| qt_en | input | 1 | Fast-trip enable |
| reg_en | input | 1 | Regulation mode select |
| cycle_mode | input | 1 | 1: auto-retry after cool-down; 0: latched until clear pulse |
| clr_n | input | 1 | Active-low fault clear pin |
| nv_en | input | 1 | Sticky (fuse) latch enable |
| cfg_clear | input | 1 | Clears the sticky flag |
| gate_off | output | 1 | 1 turns the pass transistor off |
| reg_req | output | 1 | Request to the analog loop to limit current |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The bench goes after the off-by-one edges of every window. It drives overcurrent runs one cycle short of the filter and regulation limits, and one cycle past them. A counter that forgot to restart, or that compared with the wrong limit, would trip early or late. It drives clear pulses one cycle short of the minimum width and checks the cool-down and restart lengths to the exact cycle. Wrong qualification would release a latched fault, and a misplaced state exit would switch the gate back on a cycle early or late. It also trips with the sticky flag armed and then pulses the clear pin, flips the mode and asserts reset. A flag that is tied to reset, or that the state machine can see through, would drop the fault.

// File: rtl/cb_pkg.sv
// Shared types for the overcurrent breaker.
// Assumes nothing beyond a common clock domain for all users.
package cb_pkg;
    typedef enum logic [1:0] {
        CB_RUN   = 2'd0,   // gate driven on, trip detection armed
        CB_FAULT = 2'd1,   // gate off, fault flag asserted
        CB_DELAY = 2'd2    // fault cleared, gate held off for restart delay
    } cb_state_e;
endpackage

// File: rtl/cb_oc_filter.sv
// Overcurrent qualification: filter window, regulation timeout, fast trip.
// Assumes oc_i / qt_i are synchronous to clk. A single saturating counter
// measures consecutive high samples of oc_i; the limit is picked by reg_en_i.
module cb_oc_filter #(
    parameter int FILT_CYC = 16,
    parameter int REG_CYC  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic oc_i,
    input  logic qt_i,
    input  logic qt_en_i,
    input  logic reg_en_i,
    output logic trip_o,
    output logic reg_req_o
);
    localparam int LIM_MAX = (FILT_CYC > REG_CYC) ? FILT_CYC : REG_CYC;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             slow_trip;
    logic             fast_trip;

    // Pick the window length for the active mode.
    always_comb lim = reg_en_i ? CNT_W'(REG_CYC) : CNT_W'(FILT_CYC);

    // Count consecutive overcurrent samples while running; saturate at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run_i || !oc_i)
            cnt <= '0;
        else if (cnt != CNT_W'(LIM_MAX))
            cnt <= cnt + 1'b1;
    end

    // Trip decisions and the regulation request.
    always_comb begin
        slow_trip = run_i && oc_i && (cnt >= lim);
        fast_trip = run_i && qt_en_i && qt_i;
        trip_o    = slow_trip || fast_trip;
        reg_req_o = run_i && reg_en_i && oc_i;
    end

    // R2/R5: a low sample always restarts the window.
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_i |=> (cnt == '0));

    // R4: while regulating without a trip, the timeout keeps advancing.
    a_r4_timer_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !trip_o) |=> (cnt != '0));
endmodule

// File: rtl/cb_rst_qual.sv
// Clear-pin pulse qualifier. Emits a one-cycle release on the first high
// sample that follows at least RST_MIN consecutive low samples.
// Assumes clr_n_i is already synchronous to clk.
module cb_rst_qual #(
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_i,
    output logic rel_o
);
    localparam int LOW_W = $clog2(RST_MIN + 1);

    logic [LOW_W-1:0] low_cnt;

    // Measure the current low run of the clear pin, saturating at RST_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!clr_n_i) begin
            if (low_cnt != LOW_W'(RST_MIN))
                low_cnt <= low_cnt + 1'b1;
        end else
            low_cnt <= '0;
    end

    // Release when the pin returns high after a long enough pulse.
    always_comb rel_o = clr_n_i && (low_cnt == LOW_W'(RST_MIN));

    // R9: a release is always preceded by a low sample.
    a_r9_release_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |-> !$past(clr_n_i));
endmodule

// File: rtl/cb_fault_seq.sv
// Fault sequencer: run, fault hold, restart delay. The cool-down in cycle
// mode and the restart delay in latched mode share one timer.
// Assumes CYC_CYC and PDD_CYC are at least 1.
module cb_fault_seq
    import cb_pkg::*;
#(
    parameter int CYC_CYC = 64,
    parameter int PDD_CYC = 24
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trip_i,
    input  logic      rel_i,
    input  logic      cycle_mode_i,
    output cb_state_e state_o
);
    localparam int TMAX  = (CYC_CYC > PDD_CYC) ? CYC_CYC : PDD_CYC;
    localparam int TMR_W = $clog2(TMAX + 1);

    cb_state_e        st;
    logic [TMR_W-1:0] tmr;

    // State and timer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CB_RUN;
            tmr <= '0;
        end else begin
            case (st)
                CB_RUN: begin
                    tmr <= '0;
                    if (trip_i) st <= CB_FAULT;
                end
                CB_FAULT: begin
                    if (cycle_mode_i) begin
                        if (tmr == TMR_W'(CYC_CYC - 1)) begin
                            st  <= CB_RUN;
                            tmr <= '0;
                        end else
                            tmr <= tmr + 1'b1;
                    end else begin
                        tmr <= '0;
                        if (rel_i) st <= CB_DELAY;
                    end
                end
                CB_DELAY: begin
                    if (tmr == TMR_W'(PDD_CYC - 1)) begin
                        st  <= CB_RUN;
                        tmr <= '0;
                    end else
                        tmr <= tmr + 1'b1;
                end
                default: begin
                    st  <= CB_RUN;
                    tmr <= '0;
                end
            endcase
        end
    end

    always_comb state_o = st;

    // R6: a trip while running always lands in the fault state.
    a_r6_trip_to_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CB_RUN && trip_i) |=> (st == CB_FAULT));

    // R8: in latched mode only a release leaves the fault state.
    a_r8_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CB_FAULT && !cycle_mode_i && !rel_i) |=> (st == CB_FAULT));

    // R8: the restart delay never ends in the fault state.
    a_r8_delay_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CB_DELAY) |=> (st != CB_FAULT));
endmodule

// File: rtl/cb_sticky.sv
// Fuse model: a flag that only the configuration clear removes.
// Deliberately has no reset term, because it stands in for nonvolatile storage.
// Assumes the owner holds clear_i high once at start-up to define it.
module cb_sticky (
    input  logic clk,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);
    // Set on a qualifying trip, clear only on configuration clear (clear wins).
    always_ff @(posedge clk) begin
        if (clear_i)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
    end
endmodule

// File: rtl/cb_fault_timer.sv
// Top of the overcurrent breaker. Joins the filter, the clear qualifier,
// the fault sequencer and the sticky fuse, and forms the output flags.
// Assumes all inputs are synchronous to clk.
module cb_fault_timer
    import cb_pkg::*;
#(
    parameter int FILT_CYC = 16,
    parameter int REG_CYC  = 40,
    parameter int CYC_CYC  = 64,
    parameter int PDD_CYC  = 24,
    parameter int RST_MIN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic qt_flag,
    input  logic qt_en,
    input  logic reg_en,
    input  logic cycle_mode,
    input  logic clr_n,
    input  logic nv_en,
    input  logic cfg_clear,
    output logic gate_off,
    output logic reg_req,
    output logic fault_n
);
    cb_state_e state;
    logic      nv_q;
    logic      run;
    logic      trip;
    logic      rel;

    // Detection is armed only in the running state with the fuse intact.
    always_comb run = (state == CB_RUN) && !nv_q;

    cb_oc_filter #(.FILT_CYC(FILT_CYC), .REG_CYC(REG_CYC)) filt_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .oc_i(oc_flag), .qt_i(qt_flag),
        .qt_en_i(qt_en), .reg_en_i(reg_en), .trip_o(trip), .reg_req_o(reg_req)
    );

    cb_rst_qual #(.RST_MIN(RST_MIN)) qual_i (
        .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .rel_o(rel)
    );

    cb_fault_seq #(.CYC_CYC(CYC_CYC), .PDD_CYC(PDD_CYC)) seq_i (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .rel_i(rel),
        .cycle_mode_i(cycle_mode), .state_o(state)
    );

    cb_sticky fuse_i (
        .clk(clk), .set_i(trip && nv_en && rst_n), .clear_i(cfg_clear), .flag_o(nv_q)
    );

    // Output flags: fuse overrides the sequencer.
    always_comb begin
        gate_off = (state != CB_RUN) || nv_q;
        fault_n  = !((state == CB_FAULT) || nv_q);
    end

    // R3: an enabled fast trip while running kills the gate on the next cycle.
    a_r3_fast_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (run && qt_en && qt_flag) |=> gate_off);

    // R10: the fuse survives everything except the configuration clear.
    a_r10_fuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_q && !cfg_clear) |=> (nv_q && !fault_n));

    // R11: configuration clear removes the fuse.
    a_r11_fuse_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> !nv_q);
endmodule

// File: tb/cb_fault_timer_tb_top.sv
module cb_fault_timer_tb_top;
    localparam int FILT = 16;
    localparam int REGC = 40;
    localparam int CYC  = 64;
    localparam int PDD  = 24;
    localparam int RMIN = 4;
    localparam int LMAX = (FILT > REGC) ? FILT : REGC;

    logic clk = 1'b0;
    logic rst_n = 1'b0, oc_flag = 1'b0, qt_flag = 1'b0, qt_en = 1'b1, reg_en = 1'b0;
    logic cycle_mode = 1'b1, clr_n = 1'b1, nv_en = 1'b0, cfg_clear = 1'b1;
    logic gate_off, reg_req, fault_n;

    int n_chk = 0, n_fail = 0;
    string tag = "R1";

    // reference model state (0 run, 1 fault, 2 delay)
    int m_st = 0, m_cnt = 0, m_tmr = 0, m_low = 0;
    bit m_nv = 0;
    int  mv_lim;
    bit  mv_run, mv_trip, mv_rel;

    always #5 clk = ~clk;

    cb_fault_timer dut_i (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .qt_flag(qt_flag), .qt_en(qt_en),
        .reg_en(reg_en), .cycle_mode(cycle_mode), .clr_n(clr_n), .nv_en(nv_en),
        .cfg_clear(cfg_clear), .gate_off(gate_off), .reg_req(reg_req), .fault_n(fault_n)
    );

    // Reference model built from the requirements, advanced on each edge.
    always @(posedge clk) begin
        mv_run  = (m_st == 0) && !m_nv;
        mv_lim  = reg_en ? REGC : FILT;
        mv_trip = rst_n && mv_run && ((qt_en && qt_flag) || (oc_flag && m_cnt >= mv_lim));
        mv_rel  = clr_n && (m_low >= RMIN);
        if (cfg_clear) m_nv = 0;
        else if (mv_trip && nv_en) m_nv = 1;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tmr = 0; m_low = 0;
        end else begin
            if (!clr_n) m_low = (m_low < RMIN) ? m_low + 1 : m_low;
            else m_low = 0;
            if (!mv_run || !oc_flag) m_cnt = 0;
            else if (m_cnt < LMAX) m_cnt = m_cnt + 1;
            case (m_st)
                0: begin m_tmr = 0; if (mv_trip) m_st = 1; end
                1: if (cycle_mode) begin
                       if (m_tmr == CYC - 1) begin m_st = 0; m_tmr = 0; end
                       else m_tmr = m_tmr + 1;
                   end else begin
                       m_tmr = 0;
                       if (mv_rel) m_st = 2;
                   end
                default: if (m_tmr == PDD - 1) begin m_st = 0; m_tmr = 0; end
                         else m_tmr = m_tmr + 1;
            endcase
        end
    end

    function automatic logic [2:0] model_out();
        logic go, fn, rq;
        go = (m_st != 0) || m_nv;
        fn = !((m_st == 1) || m_nv);
        rq = (m_st == 0) && !m_nv && reg_en && oc_flag;
        return {go, fn, rq};
    endfunction

    task automatic cmp_model();
        logic [2:0] exp_v;
        exp_v = model_out();
        n_chk++;
        if ({gate_off, fault_n, reg_req} !== exp_v) begin
            n_fail++;
            $display("FAIL %s model {gate_off,fault_n,reg_req} actual=%b expected=%b t=%0t",
                     tag, {gate_off, fault_n, reg_req}, exp_v, $time);
        end
    endtask

    task automatic chk(input string t, input logic act, input logic exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", t, act, exp_v, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            cmp_model();
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1; cfg_clear = 1'b0;
        // R1 reset state
        chk("R1 gate_off", gate_off, 1'b0);
        chk("R1 fault_n", fault_n, 1'b1);
        chk("R1 reg_req", reg_req, 1'b0);

        // R2 short burst, then gap, then exact limit
        tag = "R2"; oc_flag = 1; tick(FILT); oc_flag = 0; tick(1);
        chk("R2 short burst no trip", fault_n, 1'b1);
        oc_flag = 1; tick(FILT);
        chk("R2 FILT samples no trip", fault_n, 1'b1);
        tick(1);
        chk("R2 FILT+1 trips fault_n", fault_n, 1'b0);
        chk("R6 gate_off on trip", gate_off, 1'b1);

        // R7 cool-down length
        tag = "R7"; oc_flag = 0; tick(CYC - 1);
        chk("R7 still faulted", fault_n, 1'b0);
        tick(1);
        chk("R7 fault cleared", fault_n, 1'b1);
        chk("R7 gate back on", gate_off, 1'b0);

        // R12 re-trip after restart
        tag = "R12"; oc_flag = 1; tick(FILT);
        chk("R12 no early retrip", fault_n, 1'b1);
        tick(1);
        chk("R12 retrip", fault_n, 1'b0);
        oc_flag = 0; tick(CYC);

        // R3 fast trip and disable
        tag = "R3"; qt_flag = 1; tick(1);
        chk("R3 fast gate_off", gate_off, 1'b1);
        chk("R3 fast fault_n", fault_n, 1'b0);
        qt_flag = 0; tick(CYC);
        qt_en = 0; qt_flag = 1; tick(20);
        chk("R3 disabled ignored", fault_n, 1'b1);
        chk("R3 disabled gate on", gate_off, 1'b0);
        qt_flag = 0; qt_en = 1; tick(1);

        // R8 latched hold, R9 short pulse, R8 release and delay
        tag = "R8"; cycle_mode = 0; qt_flag = 1; tick(1); qt_flag = 0; tick(200);
        chk("R8 latched hold", fault_n, 1'b0);
        tag = "R9"; clr_n = 0; tick(RMIN - 1); clr_n = 1; tick(5);
        chk("R9 short pulse ignored", fault_n, 1'b0);
        tag = "R8"; clr_n = 0; tick(RMIN); clr_n = 1; tick(1);
        chk("R8 fault_n released", fault_n, 1'b1);
        chk("R8 gate held", gate_off, 1'b1);
        tick(PDD - 1);
        chk("R8 gate still held", gate_off, 1'b1);
        tick(1);
        chk("R8 gate restarts", gate_off, 1'b0);

        // R4 / R5 regulation
        tag = "R4"; cycle_mode = 1; reg_en = 1; oc_flag = 1; tick(1);
        chk("R4 reg_req high", reg_req, 1'b1);
        tick(REGC - 1); oc_flag = 0; tick(1);
        chk("R5 no trip within timeout", fault_n, 1'b1);
        chk("R4 reg_req low", reg_req, 1'b0);
        tag = "R5"; oc_flag = 1; tick(REGC);
        chk("R5 timer restarted", fault_n, 1'b1);
        tick(1);
        chk("R4 timeout trip", fault_n, 1'b0);
        oc_flag = 0; reg_en = 0; tick(CYC);

        // R10 sticky flag
        tag = "R10"; nv_en = 1; qt_flag = 1; tick(1); qt_flag = 0; nv_en = 0; tick(100);
        chk("R10 past cool-down", fault_n, 1'b0);
        clr_n = 0; tick(RMIN + 1); clr_n = 1; cycle_mode = 0; tick(2);
        chk("R10 clear pin no effect", fault_n, 1'b0);
        rst_n = 0; tick(2); rst_n = 1; tick(2);
        chk("R10 reset no effect", fault_n, 1'b0);
        chk("R10 gate held off", gate_off, 1'b1);

        // R11 configuration clear
        tag = "R11"; cycle_mode = 1; cfg_clear = 1; tick(1); cfg_clear = 0; tick(1);
        chk("R11 fault cleared", fault_n, 1'b1);
        chk("R11 gate on", gate_off, 1'b0);

        // random mix checked against the model
        tag = "R2..R12 random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 12 == 0) oc_flag = ~oc_flag;
            qt_flag = ($urandom % 80 == 0);
            if ($urandom % 300 == 0) qt_en = ~qt_en;
            if ($urandom % 400 == 0) reg_en = ~reg_en;
            if ($urandom % 500 == 0) cycle_mode = ~cycle_mode;
            if (clr_n) clr_n = !($urandom % 40 == 0);
            else clr_n = ($urandom % 4 == 0);
            nv_en = ($urandom % 50 == 0);
            cfg_clear = ($urandom % 150 == 0);
            rst_n = !($urandom % 900 == 0);
            tick(1);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule